// File: doc/BRIEF.md
# DDR SDRAM Command Rule Monitor

This block sits beside the command pins of a four-bank DDR SDRAM and samples them on every rising clock edge. The pins it samples are chip select, row strobe, column strobe, write enable, the two bank-select bits, address bit 10 and clock enable. It turns each sample into a command and keeps a flag per bank that says whether a row is open. Each command is checked against the state of the banks and against minimum spacings that are counted in clock cycles and set as parameters. Any broken rule produces a violation pulse of one cycle and a 4-bit code.

Every output is registered. The decoded command, the bank flags and the verdict for the command sampled at edge k all appear just after edge k. The burst length is a parameter, so data beats are never observed. A write with auto-precharge keeps the data bus busy for burst length / 2 cycles. Bank state is updated even for commands that break a rule, and checking goes on without interruption.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With clock enable high in the previous sample and chip select low, {ras_n,cas_n,we_n} decodes as: 111 NOP (0), 011 activate (1), 101 read (2, or 3 with auto-precharge when a10=1), 100 write (4, or 5 with a10=1), 010 precharge (6, or 7 all-bank when a10=1), 001 refresh (8), 000 mode write (10, or 11 extended when ba[0]=1), 110 burst stop (12). Chip select high decodes as NOP. The code appears on cmd_out in the cycle after the sampling edge.
- R2: The bank index is {ba[1],ba[0]}, so bank A is 0 and bank D is 3. An activate sets bank_open[index]. A single-bank precharge clears it.
- R3: A precharge with a10=1 clears every bit of bank_open, whatever the value on ba.
- R4: A mode write, extended mode write, refresh or self-refresh entry issued while any bank is open gives code 3.
- R5: Any command other than NOP that comes fewer than T_MRD (default 2) cycles after a mode write gives code 4. This check takes priority over every other rule.
- R6: A read or write to an idle bank gives code 1. An activate to an open bank gives code 2. A single-bank precharge to an idle bank gives code 11.
- R7: A read or write fewer than T_RCD (3) cycles after the activate of its bank gives code 5.
- R8: A precharge fewer than T_RAS (5) cycles after the activate of an open bank it closes gives code 6.
- R9: An activate fewer than T_RC (9) cycles after the previous activate of the same bank gives code 7. An activate fewer than T_RRD (2) cycles after any activate gives code 8.
- R10: A read or write within burst length/2 cycles after a write with auto-precharge gives code 9. Auto-precharge closes the bank. An activate gives code 10 if it comes fewer than T_RP (3) cycles after a precharge of its bank, or fewer than burst length/2 + T_RP cycles after an auto-precharge command. This precharge-time check takes priority over code 7.
- R11: viol is high for exactly one cycle, with a nonzero viol_code, for each violating command. In every other cycle viol is low and viol_code is 0.
- R12: A refresh sampled with cke low while the previous cke was high decodes as self-refresh entry (9). Any sample taken while the previous cke was low decodes as 13 (suspended) and leaves the bank state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select bits |
| a10 | input | 1 | Address bit 10 (auto-precharge / all-bank) |
| cke | input | 1 | Clock enable |
| cmd_out | output | 4 | Decoded command code |
| bank_open | output | 4 | One open-row flag per bank |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 4 | Code of the broken rule |

## Verification
The assertions check a set of invariants on every cycle. After an all-bank precharge no bank is open. A global command that passes its check always finds every bank closed. A suspended sample never moves the bank flags. A bank still waiting out its precharge time is never flagged open. The spacing counters step down by exactly one per cycle. Only the directed scenarios can show that each spacing rule fires below its limit and stays quiet at it, which codes win when several rules are broken at once, and how the mode-write and self-refresh decodes are distinguished.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

   typedef enum logic [3:0] {
      K_NOP   = 4'd0,
      K_ACT   = 4'd1,
      K_RD    = 4'd2,
      K_RDA   = 4'd3,
      K_WR    = 4'd4,
      K_WRA   = 4'd5,
      K_PRE   = 4'd6,
      K_PREA  = 4'd7,
      K_REF   = 4'd8,
      K_SREF  = 4'd9,
      K_MRS   = 4'd10,
      K_EMRS  = 4'd11,
      K_BST   = 4'd12,
      K_HOLD  = 4'd13
   } mon_cmd_e;

   typedef enum logic [3:0] {
      V_NONE     = 4'd0,
      V_COL_IDLE = 4'd1,
      V_ACT_OPEN = 4'd2,
      V_NOT_IDLE = 4'd3,
      V_MRD      = 4'd4,
      V_RCD      = 4'd5,
      V_RAS      = 4'd6,
      V_RC       = 4'd7,
      V_RRD      = 4'd8,
      V_WAP      = 4'd9,
      V_RP       = 4'd10,
      V_PRE_IDLE = 4'd11
   } mon_err_e;

   function automatic int unsigned max2(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdram_mon_decode.sv
module sdram_mon_decode
   import sdram_mon_pkg::*;
(
   input  logic     cs_n,
   input  logic     ras_n,
   input  logic     cas_n,
   input  logic     we_n,
   input  logic     ba0,
   input  logic     a10,
   input  logic     cke,
   input  logic     cke_prev,
   output mon_cmd_e cmd
);

   always_comb begin
      cmd = K_NOP;
      if (!cke_prev) begin
         cmd = K_HOLD;
      end else if (!cs_n) begin
         case ({ras_n, cas_n, we_n})
            3'b111:  cmd = K_NOP;
            3'b011:  cmd = K_ACT;
            3'b101:  cmd = a10 ? K_RDA : K_RD;
            3'b100:  cmd = a10 ? K_WRA : K_WR;
            3'b110:  cmd = K_BST;
            3'b010:  cmd = a10 ? K_PREA : K_PRE;
            3'b001:  cmd = cke ? K_REF : K_SREF;
            default: cmd = ba0 ? K_EMRS : K_MRS;
         endcase
      end
   end

endmodule

// File: rtl/sdram_mon_timer.sv
module sdram_mon_timer #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         busy
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (load)      cnt <= load_val;
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   // R9: spacing windows shrink by one per idle cycle
   a_r9_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sdram_mon_bank.sv
module sdram_mon_bank
   import sdram_mon_pkg::*;
#(
   parameter int unsigned T_RCD     = 3,
   parameter int unsigned T_RAS     = 5,
   parameter int unsigned T_RC      = 9,
   parameter int unsigned T_RP      = 3,
   parameter int unsigned BURST_CYC = 2,
   parameter int unsigned W         = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  mon_cmd_e cmd,
   input  logic     hit,
   output logic     is_open,
   output logic     rcd_busy,
   output logic     ras_busy,
   output logic     rc_busy,
   output logic     rp_busy
);

   localparam logic [W-1:0] L_RCD = W'(T_RCD - 1);
   localparam logic [W-1:0] L_RAS = W'(T_RAS - 1);
   localparam logic [W-1:0] L_RC  = W'(T_RC - 1);
   localparam logic [W-1:0] L_RP  = W'(T_RP - 1);
   localparam logic [W-1:0] L_APR = W'(BURST_CYC + T_RP - 1);

   logic do_act, do_close, do_auto;
   logic [W-1:0] rp_val;

   assign do_act   = hit && (cmd == K_ACT);
   assign do_auto  = hit && is_open && ((cmd == K_RDA) || (cmd == K_WRA));
   assign do_close = is_open && (((cmd == K_PRE) && hit) || (cmd == K_PREA));
   assign rp_val   = do_act ? '0 : (do_auto ? L_APR : L_RP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   is_open <= 1'b0;
      else if (do_act)              is_open <= 1'b1;
      else if (do_close || do_auto) is_open <= 1'b0;
   end

   sdram_mon_timer #(.W(W)) u_rcd (
      .clk(clk), .rst_n(rst_n), .load(do_act), .load_val(L_RCD), .busy(rcd_busy));
   sdram_mon_timer #(.W(W)) u_ras (
      .clk(clk), .rst_n(rst_n), .load(do_act), .load_val(L_RAS), .busy(ras_busy));
   sdram_mon_timer #(.W(W)) u_rc (
      .clk(clk), .rst_n(rst_n), .load(do_act), .load_val(L_RC), .busy(rc_busy));
   sdram_mon_timer #(.W(W)) u_rp (
      .clk(clk), .rst_n(rst_n), .load(do_act || do_close || do_auto),
      .load_val(rp_val), .busy(rp_busy));

   // R10: a bank still in its precharge time is never open
   a_r10_rp_closed: assert property (@(posedge clk) disable iff (!rst_n)
      rp_busy |-> !is_open);

endmodule

// File: rtl/sdram_mon_rules.sv
module sdram_mon_rules
   import sdram_mon_pkg::*;
#(
   parameter int unsigned NB = 4,
   parameter int unsigned BB = 2
) (
   input  mon_cmd_e        cmd,
   input  logic [BB-1:0]   idx,
   input  logic [NB-1:0]   open_v,
   input  logic [NB-1:0]   rcd_v,
   input  logic [NB-1:0]   ras_v,
   input  logic [NB-1:0]   rc_v,
   input  logic [NB-1:0]   rp_v,
   input  logic            mrd_busy,
   input  logic            rrd_busy,
   input  logic            wap_busy,
   output mon_err_e        code
);

   logic sel_open;
   assign sel_open = open_v[idx];

   always_comb begin
      code = V_NONE;
      if (mrd_busy && (cmd != K_NOP) && (cmd != K_HOLD)) begin
         code = V_MRD;
      end else begin
         case (cmd)
            K_ACT: begin
               if (sel_open)        code = V_ACT_OPEN;
               else if (rp_v[idx])  code = V_RP;
               else if (rc_v[idx])  code = V_RC;
               else if (rrd_busy)   code = V_RRD;
            end
            K_RD, K_RDA, K_WR, K_WRA: begin
               if (!sel_open)       code = V_COL_IDLE;
               else if (wap_busy)   code = V_WAP;
               else if (rcd_v[idx]) code = V_RCD;
            end
            K_PRE: begin
               if (!sel_open)       code = V_PRE_IDLE;
               else if (ras_v[idx]) code = V_RAS;
            end
            K_PREA: begin
               if (|(open_v & ras_v)) code = V_RAS;
            end
            K_REF, K_SREF, K_MRS, K_EMRS: begin
               if (|open_v)         code = V_NOT_IDLE;
            end
            default: code = V_NONE;
         endcase
      end
   end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdram_mon_pkg::*;
#(
   parameter int unsigned BANK_BITS = 2,
   parameter int unsigned T_RCD     = 3,
   parameter int unsigned T_RAS     = 5,
   parameter int unsigned T_RC      = 9,
   parameter int unsigned T_RRD     = 2,
   parameter int unsigned T_RP      = 3,
   parameter int unsigned T_MRD     = 2,
   parameter int unsigned BURST_LEN = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs_n,
   input  logic                       ras_n,
   input  logic                       cas_n,
   input  logic                       we_n,
   input  logic [BANK_BITS-1:0]       ba,
   input  logic                       a10,
   input  logic                       cke,
   output logic [3:0]                 cmd_out,
   output logic [(1<<BANK_BITS)-1:0]  bank_open,
   output logic                       viol,
   output logic [3:0]                 viol_code
);

   localparam int unsigned NB        = 1 << BANK_BITS;
   localparam int unsigned BURST_CYC = BURST_LEN / 2;
   localparam int unsigned T_MAX     = max2(max2(max2(T_RC, T_RAS), max2(T_RCD, T_MRD)),
                                            max2(T_RRD, BURST_CYC + T_RP));
   localparam int unsigned W         = $clog2(T_MAX + 1);

   if (BURST_LEN != 2 && BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_bl
      $error("burst length must be 2, 4 or 8");
   end
   if (T_RCD < 1 || T_RAS < 1 || T_RC < 1 || T_RRD < 1 || T_RP < 1 || T_MRD < 1)
   begin : g_bad_t
      $error("every spacing must be at least one cycle");
   end
   if (BANK_BITS < 1 || BANK_BITS > 3) begin : g_bad_bb
      $error("bank select width out of range");
   end

   logic       cke_prev;
   mon_cmd_e   cmd;
   mon_err_e   code;
   logic [NB-1:0] open_v, rcd_v, ras_v, rc_v, rp_v;
   logic mrd_busy, rrd_busy, wap_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cke_prev <= 1'b1;
      else        cke_prev <= cke;
   end

   sdram_mon_decode u_dec (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .ba0(ba[0]), .a10(a10), .cke(cke), .cke_prev(cke_prev), .cmd(cmd));

   for (genvar b = 0; b < NB; b++) begin : g_bank
      sdram_mon_bank #(
         .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
         .BURST_CYC(BURST_CYC), .W(W)
      ) u_bank (
         .clk(clk), .rst_n(rst_n), .cmd(cmd),
         .hit(ba == BANK_BITS'(b)),
         .is_open(open_v[b]), .rcd_busy(rcd_v[b]), .ras_busy(ras_v[b]),
         .rc_busy(rc_v[b]), .rp_busy(rp_v[b]));
   end

   sdram_mon_timer #(.W(W)) u_mrd (
      .clk(clk), .rst_n(rst_n), .load((cmd == K_MRS) || (cmd == K_EMRS)),
      .load_val(W'(T_MRD - 1)), .busy(mrd_busy));
   sdram_mon_timer #(.W(W)) u_rrd (
      .clk(clk), .rst_n(rst_n), .load(cmd == K_ACT),
      .load_val(W'(T_RRD - 1)), .busy(rrd_busy));
   sdram_mon_timer #(.W(W)) u_wap (
      .clk(clk), .rst_n(rst_n), .load(cmd == K_WRA),
      .load_val(W'(BURST_CYC)), .busy(wap_busy));

   sdram_mon_rules #(.NB(NB), .BB(BANK_BITS)) u_rules (
      .cmd(cmd), .idx(ba), .open_v(open_v), .rcd_v(rcd_v), .ras_v(ras_v),
      .rc_v(rc_v), .rp_v(rp_v), .mrd_busy(mrd_busy), .rrd_busy(rrd_busy),
      .wap_busy(wap_busy), .code(code));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_out   <= 4'(K_NOP);
         viol      <= 1'b0;
         viol_code <= 4'(V_NONE);
      end else begin
         cmd_out   <= 4'(cmd);
         viol      <= (code != V_NONE);
         viol_code <= 4'(code);
      end
   end

   assign bank_open = open_v;

   // R3: all-bank precharge leaves no open row
   a_r3_prea_closes_all: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_out == 4'(K_PREA)) |-> (bank_open == '0));

   // R4: a legal global command finds every bank closed
   a_r4_global_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_out == 4'(K_MRS) || cmd_out == 4'(K_EMRS) || cmd_out == 4'(K_REF) ||
        cmd_out == 4'(K_SREF)) && !viol) |-> (bank_open == '0));

   // R12: a suspended sample leaves the bank flags alone
   a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_out == 4'(K_HOLD)) |-> $stable(bank_open));

   // R2: an activate always leaves some bank open
   a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_out == 4'(K_ACT)) |-> (bank_open != '0));

endmodule

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;
   import sdram_mon_pkg::*;

   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] ba = 2'd0;
   logic a10 = 1'b0;
   logic cke = 1'b1;
   logic cke_lvl = 1'b1;
   logic [3:0] cmd_out, viol_code, bank_open;
   logic viol;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_cmd_monitor uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .a10(a10), .cke(cke), .cmd_out(cmd_out),
      .bank_open(bank_open), .viol(viol), .viol_code(viol_code));

   task automatic send(input logic c, input logic r, input logic k, input logic w,
                       input logic [1:0] b, input logic a);
      @(negedge clk);
      cs_n = c; ras_n = r; cas_n = k; we_n = w; ba = b; a10 = a; cke = cke_lvl;
      @(posedge clk);
      #1;
   endtask

   task automatic exp(input string tag, input mon_cmd_e ec, input mon_err_e ee,
                      input logic [3:0] eo);
      total++;
      if (cmd_out !== 4'(ec) || viol !== (ee != V_NONE) || viol_code !== 4'(ee) ||
          bank_open !== eo) begin
         bad++;
         $display("FAIL %s: cmd=%0d viol=%0b code=%0d open=%b expected cmd=%0d viol=%0b code=%0d open=%b",
                  tag, cmd_out, viol, viol_code, bank_open, ec, (ee != V_NONE), ee, eo);
      end
   endtask

   task automatic c_nop();           send(0,1,1,1,2'd0,0); endtask
   task automatic c_desel();         send(1,0,0,0,2'd0,0); endtask
   task automatic c_act(input int b); send(0,0,1,1,2'(b),0); endtask
   task automatic c_rd(input int b, input logic ap); send(0,1,0,1,2'(b),ap); endtask
   task automatic c_wr(input int b, input logic ap); send(0,1,0,0,2'(b),ap); endtask
   task automatic c_pre(input int b); send(0,0,1,0,2'(b),0); endtask
   task automatic c_prea(input int b); send(0,0,1,0,2'(b),1); endtask
   task automatic c_ref();           send(0,0,0,1,2'd0,0); endtask
   task automatic c_mrs(input int b); send(0,0,0,0,2'(b),0); endtask
   task automatic c_bst();           send(0,1,1,0,2'd0,0); endtask
   task automatic nops(input int n);
      for (int i = 0; i < n; i++) c_nop();
   endtask

   task automatic t_decode();
      c_mrs(0);    exp("R1 mode write", K_MRS, V_NONE, 4'b0000);
      c_nop();     exp("R1 nop", K_NOP, V_NONE, 4'b0000);
      c_mrs(1);    exp("R1 R5 extended mode at gap 2", K_EMRS, V_NONE, 4'b0000);
      nops(2);
      c_ref();     exp("R1 refresh", K_REF, V_NONE, 4'b0000);
      c_desel();   exp("R1 deselect is nop", K_NOP, V_NONE, 4'b0000);
      c_act(0);    exp("R1 activate", K_ACT, V_NONE, 4'b0001);
      nops(3);
      c_rd(0,0);   exp("R1 read", K_RD, V_NONE, 4'b0001);
      c_wr(0,0);   exp("R1 write", K_WR, V_NONE, 4'b0001);
      c_bst();     exp("R1 burst stop", K_BST, V_NONE, 4'b0001);
      c_rd(0,1);   exp("R1 R10 read autoprecharge closes", K_RDA, V_NONE, 4'b0000);
      nops(4);
      c_act(0);    exp("R10 activate at burst+precharge limit", K_ACT, V_NONE, 4'b0001);
      nops(4);
      c_pre(0);    exp("R8 precharge at row-active limit", K_PRE, V_NONE, 4'b0000);
      c_prea(0);   exp("R1 all-bank precharge", K_PREA, V_NONE, 4'b0000);
      nops(3);
   endtask

   task automatic t_banks();
      c_act(0);    exp("R2 bank A", K_ACT, V_NONE, 4'b0001);
      c_nop();
      c_act(1);    exp("R2 R9 bank B at gap 2", K_ACT, V_NONE, 4'b0011);
      c_nop();
      c_act(2);    exp("R2 bank C", K_ACT, V_NONE, 4'b0111);
      c_nop();
      c_act(3);    exp("R2 bank D", K_ACT, V_NONE, 4'b1111);
      nops(4);
      c_pre(2);    exp("R2 close bank C", K_PRE, V_NONE, 4'b1011);
      c_prea(1);   exp("R3 all-bank ignores ba", K_PREA, V_NONE, 4'b0000);
      nops(3);
   endtask

   task automatic t_state();
      c_rd(1,0);   exp("R6 read idle bank", K_RD, V_COL_IDLE, 4'b0000);
      c_nop();     exp("R11 pulse lasts one cycle", K_NOP, V_NONE, 4'b0000);
      c_pre(1);    exp("R6 precharge idle bank", K_PRE, V_PRE_IDLE, 4'b0000);
      c_act(1);    exp("R2 open bank B", K_ACT, V_NONE, 4'b0010);
      c_act(1);    exp("R6 activate open bank", K_ACT, V_ACT_OPEN, 4'b0010);
      c_ref();     exp("R4 refresh with open bank", K_REF, V_NOT_IDLE, 4'b0010);
      c_nop();
      c_mrs(0);    exp("R4 mode write with open bank", K_MRS, V_NOT_IDLE, 4'b0010);
      nops(2);
      c_pre(1);    exp("R11 checking continues", K_PRE, V_NONE, 4'b0000);
      nops(3);
   endtask

   task automatic t_mrd();
      c_mrs(0);    exp("R5 mode write", K_MRS, V_NONE, 4'b0000);
      c_rd(0,0);   exp("R5 gap 1 wins over idle read", K_RD, V_MRD, 4'b0000);
      c_mrs(0);    exp("R5 gap 2 legal", K_MRS, V_NONE, 4'b0000);
      c_nop();
      c_act(2);    exp("R5 activate after gap", K_ACT, V_NONE, 4'b0100);
      nops(4);
      c_pre(2);    exp("R8 close bank C", K_PRE, V_NONE, 4'b0000);
      nops(3);
   endtask

   task automatic t_timing();
      c_act(0);    exp("R7 open A", K_ACT, V_NONE, 4'b0001);
      c_rd(0,0);   exp("R7 read too soon", K_RD, V_RCD, 4'b0001);
      c_act(1);    exp("R9 second bank at gap 2", K_ACT, V_NONE, 4'b0011);
      c_act(2);    exp("R9 activate gap 1", K_ACT, V_RRD, 4'b0111);
      c_pre(0);    exp("R8 precharge too soon", K_PRE, V_RAS, 4'b0110);
      nops(2);
      c_act(0);    exp("R9 same-bank cycle too short", K_ACT, V_RC, 4'b0111);
      c_pre(1);    exp("R8 close B", K_PRE, V_NONE, 4'b0101);
      c_act(1);    exp("R10 precharge time wins", K_ACT, V_RP, 4'b0111);
      nops(5);
      c_prea(0);   exp("R3 close all", K_PREA, V_NONE, 4'b0000);
      nops(3);
   endtask

   task automatic t_wap();
      c_act(0);    exp("R10 open A", K_ACT, V_NONE, 4'b0001);
      c_nop();
      c_act(3);    exp("R10 open D", K_ACT, V_NONE, 4'b1001);
      nops(2);
      c_wr(3,1);   exp("R10 write autoprecharge", K_WRA, V_NONE, 4'b0001);
      c_rd(0,0);   exp("R10 read in burst", K_RD, V_WAP, 4'b0001);
      c_wr(0,0);   exp("R10 write at burst end", K_WR, V_WAP, 4'b0001);
      c_rd(0,0);   exp("R10 read after burst", K_RD, V_NONE, 4'b0001);
      c_act(3);    exp("R10 reopen before precharge time", K_ACT, V_RP, 4'b1001);
      nops(4);
      c_prea(2);   exp("R3 close all", K_PREA, V_NONE, 4'b0000);
      nops(3);
   endtask

   task automatic t_cke();
      cke_lvl = 1'b0;
      c_ref();     exp("R12 self refresh entry", K_SREF, V_NONE, 4'b0000);
      c_act(1);    exp("R12 suspended activate ignored", K_HOLD, V_NONE, 4'b0000);
      cke_lvl = 1'b1;
      c_nop();     exp("R12 exit cycle suspended", K_HOLD, V_NONE, 4'b0000);
      c_act(1);    exp("R12 active again", K_ACT, V_NONE, 4'b0010);
      cke_lvl = 1'b0;
      c_ref();     exp("R4 self refresh with open bank", K_SREF, V_NOT_IDLE, 4'b0010);
      cke_lvl = 1'b1;
      c_nop();     exp("R12 suspended keeps state", K_HOLD, V_NONE, 4'b0010);
      nops(2);
      c_pre(1);    exp("R2 close B", K_PRE, V_NONE, 4'b0000);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      total++;
      if (cmd_out !== 4'(K_NOP) || viol !== 1'b0 || viol_code !== 4'd0 || bank_open !== 4'd0) begin
         bad++;
         $display("FAIL R11 reset: cmd=%0d viol=%0b code=%0d open=%b expected 0 0 0 0000",
                  cmd_out, viol, viol_code, bank_open);
      end
      @(negedge clk); rst_n = 1'b1;
      nops(2);
      t_decode();
      t_banks();
      t_state();
      t_mrd();
      t_timing();
      t_wap();
      t_cke();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule